// File: doc/BRIEF.md
# Clock Synthesizer Parameter Search Engine

This block takes a desired output clock frequency in kHz and searches for the multiplier M, divider N and post-divider exponent R of a frequency synthesizer. The synthesizer model is F_vco = F_base * M / N and F_out = F_vco / 2^R. The limits on M, N and R, the permitted VCO window and the reference frequency F_base are all inputs, captured when a request is accepted.

Selection happens in two phases. The first fixes R. It starts from the largest allowed exponent and lowers it, one step per cycle, while the scaled VCO target stays above the VCO maximum. The second phase walks M and N upward together. For every pair it computes an integer VCO estimate with a shared one-bit-per-cycle restoring divider. Whenever the estimate does not exceed the target, M advances; otherwise N advances. The pair with the smallest absolute error seen so far is kept.

The caller raises `start` for one cycle while the block is idle. It then waits for `done` and reads `m_out`, `n_out` and `r_out`, or sees `error` raised together with `done`.

Top module: `pll_param_search`

## Requirements
- R1: After reset, busy, done and error are low and m_out, n_out and r_out are zero.
- R2: A start pulse while busy is low captures every request input and raises busy on the next cycle. A start pulse while busy is high is ignored: the running search finishes with the result of the captured request.
- R3: The VCO target is f_want shifted left by r_max within 32 bits. If shifting it back right by r_max does not give f_want, the request ends with error.
- R4: While the current exponent exceeds r_min and the VCO target exceeds vco_max, the exponent drops by one and the target halves. The final exponent is reported in r_out.
- R5: If the VCO target left after R4 is below vco_min or above vco_max, the request ends with error.
- R6: The walk starts at M = m_min, N = n_min and runs while M <= m_max and N <= n_max. Counters are one bit wider than the limits, so a limit of all ones still terminates. If no pair is visited, the result is M = N = 0 with the R from R4 and no error.
- R7: Each pair's estimate is (f_base * M, truncated to 32 bits) / N, rounded down; a divisor of zero gives all ones. Each estimate takes at least 32 cycles of the divider, and busy stays high throughout.
- R8: The best error starts at all ones. The kept pair changes only on a strictly smaller absolute error, so among equal errors the earliest visited pair wins.
- R9: After each pair, M increments when the estimate is at or below the VCO target; otherwise N increments.
- R10: On completion busy falls and done rises in the same cycle. done, error and the outputs hold until the next accepted start. While error is high, m_out, n_out and r_out are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, honoured only when idle |
| f_want | input | 32 | Desired output frequency in kHz |
| f_base | input | 32 | Reference frequency in kHz |
| m_min | input | 16 | Smallest multiplier |
| m_max | input | 16 | Largest multiplier |
| n_min | input | 16 | Smallest divider |
| n_max | input | 16 | Largest divider |
| r_min | input | 4 | Smallest post-divider exponent |
| r_max | input | 4 | Largest post-divider exponent |
| vco_min | input | 32 | Lowest permitted VCO frequency |
| vco_max | input | 32 | Highest permitted VCO frequency |
| busy | output | 1 | Search in progress |
| done | output | 1 | Result valid |
| error | output | 1 | Request rejected |
| m_out | output | 16 | Chosen multiplier |
| n_out | output | 16 | Chosen divider |
| r_out | output | 4 | Chosen exponent |

## Verification
The bench targets the following corner cases; the failure each would expose is given in parentheses.
- A shift that loses upper bits of the request (a design that skips the round-trip test would return a meaningless VCO target without error).
- An exponent floor that stops the halving while the target is still too high (a design that ignores r_min would wrongly succeed).
- An empty M range (a wrong loop test would run a pair or never finish).
- Equal errors met later in the walk (a non-strict comparison would swap in the later pair).
- A second start pulse mid-search and several idle cycles after done (a design that re-captures inputs, or lets outputs drift, would return a result for the wrong request).

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;
  localparam int unsigned FREQ_W = 32;
  localparam int unsigned MN_W   = 16;
  localparam int unsigned EXP_W  = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCALE = 2'd1,
    ST_PAIR  = 2'd2,
    ST_WAIT  = 2'd3
  } srch_state_t;
endpackage

// File: rtl/pll_udiv.sv
// Restoring unsigned divider, one quotient bit per cycle.
module pll_udiv #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quot,
  output logic         fin
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, rem_d;
  logic [W-1:0]  quo_q, quo_d;
  logic [W-1:0]  dvs_q, dvs_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          fin_q, fin_d;
  logic [W:0]    shifted;
  logic [W:0]    trial;

  assign shifted = {rem_q, quo_q[W-1]};
  assign trial   = shifted - {1'b0, dvs_q};

  always_comb begin
    rem_d = rem_q;
    quo_d = quo_q;
    dvs_d = dvs_q;
    cnt_d = cnt_q;
    fin_d = 1'b0;
    if (go) begin
      rem_d = '0;
      quo_d = dividend;
      dvs_d = divisor;
      cnt_d = CW'(W);
    end else if (cnt_q != '0) begin
      if (!trial[W]) begin
        rem_d = trial[W-1:0];
        quo_d = {quo_q[W-2:0], 1'b1};
      end else begin
        rem_d = shifted[W-1:0];
        quo_d = {quo_q[W-2:0], 1'b0};
      end
      cnt_d = cnt_q - 1'b1;
      fin_d = (cnt_q == CW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
      fin_q <= 1'b0;
    end else begin
      rem_q <= rem_d;
      quo_q <= quo_d;
      dvs_q <= dvs_d;
      cnt_q <= cnt_d;
      fin_q <= fin_d;
    end
  end

  assign quot = quo_q;
  assign fin  = fin_q;
endmodule

// File: rtl/pll_rsel.sv
// Exponent reduction decision and VCO window test.
module pll_rsel #(
  parameter int unsigned FW = 32,
  parameter int unsigned RW = 4
) (
  input  logic [FW-1:0] vco,
  input  logic [RW-1:0] r_cur,
  input  logic [RW-1:0] r_floor,
  input  logic [FW-1:0] win_lo,
  input  logic [FW-1:0] win_hi,
  output logic          shrink,
  output logic          outside
);
  logic above;
  assign above   = vco > win_hi;
  assign shrink  = (r_cur > r_floor) && above;
  assign outside = (vco < win_lo) || above;
endmodule

// File: rtl/pll_err_track.sv
// Absolute error, improvement test and walk direction for one pair.
module pll_err_track #(
  parameter int unsigned FW = 32
) (
  input  logic [FW-1:0] est,
  input  logic [FW-1:0] target,
  input  logic [FW-1:0] best_err,
  output logic [FW-1:0] delta,
  output logic          better,
  output logic          step_m
);
  assign step_m = est <= target;
  assign delta  = step_m ? (target - est) : (est - target);
  assign better = delta < best_err;
endmodule

// File: rtl/pll_param_search.sv
module pll_param_search
  import pll_search_pkg::*;
#(
  parameter int unsigned FW = FREQ_W,
  parameter int unsigned MW = MN_W,
  parameter int unsigned RW = EXP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [FW-1:0] f_want,
  input  logic [FW-1:0] f_base,
  input  logic [MW-1:0] m_min,
  input  logic [MW-1:0] m_max,
  input  logic [MW-1:0] n_min,
  input  logic [MW-1:0] n_max,
  input  logic [RW-1:0] r_min,
  input  logic [RW-1:0] r_max,
  input  logic [FW-1:0] vco_min,
  input  logic [FW-1:0] vco_max,
  output logic          busy,
  output logic          done,
  output logic          error,
  output logic [MW-1:0] m_out,
  output logic [MW-1:0] n_out,
  output logic [RW-1:0] r_out
);
  localparam int unsigned CW  = MW + 1;
  localparam int unsigned PAD = FW - CW;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  srch_state_t st_q, st_d;
  logic [FW-1:0] base_q, base_d, vlo_q, vlo_d, vhi_q, vhi_d;
  logic [MW-1:0] mhi_q, mhi_d, nhi_q, nhi_d, mlo_q, mlo_d, nlo_q, nlo_d;
  logic [RW-1:0] rlo_q, rlo_d, ar_q, ar_d;
  logic [FW-1:0] vco_q, vco_d, best_q, best_d;
  logic          ovf_q, ovf_d;
  logic [CW-1:0] am_q, am_d, an_q, an_d;
  logic [MW-1:0] bm_q, bm_d, bn_q, bn_d;
  logic          done_q, done_d, err_q, err_d;
  logic [MW-1:0] mo_q, mo_d, no_q, no_d;
  logic [RW-1:0] ro_q, ro_d;

  logic [FW-1:0] shl;
  logic [FW-1:0] prod;
  logic [FW-1:0] dvs;
  logic [FW-1:0] est;
  logic          div_go, div_fin;
  logic          shrink, outside;
  logic [FW-1:0] delta;
  logic          better, step_m;
  logic          in_range;

  assign shl      = f_want << r_max;
  assign prod     = base_q * {{PAD{1'b0}}, am_q};
  assign dvs      = {{PAD{1'b0}}, an_q};
  assign in_range = (am_q <= {1'b0, mhi_q}) && (an_q <= {1'b0, nhi_q});

  pll_udiv #(.W(FW)) u_div (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .go       (div_go),
    .dividend (prod),
    .divisor  (dvs),
    .quot     (est),
    .fin      (div_fin)
  );

  pll_rsel #(.FW(FW), .RW(RW)) u_rsel (
    .vco     (vco_q),
    .r_cur   (ar_q),
    .r_floor (rlo_q),
    .win_lo  (vlo_q),
    .win_hi  (vhi_q),
    .shrink  (shrink),
    .outside (outside)
  );

  pll_err_track #(.FW(FW)) u_trk (
    .est      (est),
    .target   (vco_q),
    .best_err (best_q),
    .delta    (delta),
    .better   (better),
    .step_m   (step_m)
  );

  always_comb begin
    st_d   = st_q;
    base_d = base_q;  vlo_d = vlo_q;  vhi_d = vhi_q;
    mlo_d  = mlo_q;   mhi_d = mhi_q;  nlo_d = nlo_q;  nhi_d = nhi_q;
    rlo_d  = rlo_q;   ar_d  = ar_q;   vco_d = vco_q;  ovf_d = ovf_q;
    best_d = best_q;  am_d  = am_q;   an_d  = an_q;
    bm_d   = bm_q;    bn_d  = bn_q;
    done_d = done_q;  err_d = err_q;
    mo_d   = mo_q;    no_d  = no_q;   ro_d  = ro_q;
    div_go = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          base_d = f_base;  vlo_d = vco_min;  vhi_d = vco_max;
          mlo_d  = m_min;   mhi_d = m_max;
          nlo_d  = n_min;   nhi_d = n_max;
          rlo_d  = r_min;   ar_d  = r_max;
          vco_d  = shl;
          ovf_d  = (shl >> r_max) != f_want;
          done_d = 1'b0;    err_d = 1'b0;
          mo_d   = '0;      no_d  = '0;   ro_d = '0;
          st_d   = ST_SCALE;
        end
      end
      ST_SCALE: begin
        if (ovf_q || (!shrink && outside)) begin
          done_d = 1'b1;
          err_d  = 1'b1;
          st_d   = ST_IDLE;
        end else if (shrink) begin
          ar_d  = ar_q - 1'b1;
          vco_d = vco_q >> 1;
        end else begin
          am_d   = {1'b0, mlo_q};
          an_d   = {1'b0, nlo_q};
          best_d = '1;
          bm_d   = '0;
          bn_d   = '0;
          st_d   = ST_PAIR;
        end
      end
      ST_PAIR: begin
        if (in_range) begin
          div_go = 1'b1;
          st_d   = ST_WAIT;
        end else begin
          mo_d   = bm_q;
          no_d   = bn_q;
          ro_d   = ar_q;
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      ST_WAIT: begin
        if (div_fin) begin
          if (better) begin
            best_d = delta;
            bm_d   = am_q[MW-1:0];
            bn_d   = an_q[MW-1:0];
          end
          if (step_m) am_d = am_q + 1'b1;
          else        an_d = an_q + 1'b1;
          st_d = ST_PAIR;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q   <= ST_IDLE;
      base_q <= '0;  vlo_q <= '0;  vhi_q <= '0;
      mlo_q  <= '0;  mhi_q <= '0;  nlo_q <= '0;  nhi_q <= '0;
      rlo_q  <= '0;  ar_q  <= '0;  vco_q <= '0;  ovf_q <= 1'b0;
      best_q <= '0;  am_q  <= '0;  an_q  <= '0;
      bm_q   <= '0;  bn_q  <= '0;
      done_q <= 1'b0; err_q <= 1'b0;
      mo_q   <= '0;  no_q  <= '0;  ro_q  <= '0;
    end else begin
      st_q   <= st_d;
      base_q <= base_d; vlo_q <= vlo_d; vhi_q <= vhi_d;
      mlo_q  <= mlo_d;  mhi_q <= mhi_d; nlo_q <= nlo_d; nhi_q <= nhi_d;
      rlo_q  <= rlo_d;  ar_q  <= ar_d;  vco_q <= vco_d; ovf_q <= ovf_d;
      best_q <= best_d; am_q  <= am_d;  an_q  <= an_d;
      bm_q   <= bm_d;   bn_q  <= bn_d;
      done_q <= done_d; err_q <= err_d;
      mo_q   <= mo_d;   no_q  <= no_d;  ro_q  <= ro_d;
    end
  end

  assign busy  = st_q != ST_IDLE;
  assign done  = done_q;
  assign error = err_q;
  assign m_out = mo_q;
  assign n_out = no_q;
  assign r_out = ro_q;
endmodule

// File: rtl/pll_param_search_chk.sv
module pll_param_search_chk #(
  parameter int unsigned MW = 16,
  parameter int unsigned RW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          error,
  input logic [MW-1:0] m_out,
  input logic [MW-1:0] n_out,
  input logic [RW-1:0] r_out
);
  assert_busy_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_done_after_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  assert_busy_done_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  assert_err_with_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done);

  assert_err_zero_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (m_out == '0) && (n_out == '0) && (r_out == '0));

  assert_hold_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done && $stable(error) && $stable(m_out)
                         && $stable(n_out) && $stable(r_out));
endmodule

bind pll_param_search pll_param_search_chk #(.MW(MW), .RW(RW)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .busy  (busy),
  .done  (done),
  .error (error),
  .m_out (m_out),
  .n_out (n_out),
  .r_out (r_out)
);

// File: tb/pll_param_search_tb.sv
`timescale 1ns/1ps
module pll_param_search_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] f_want = '0, f_base = '0, vco_min = '0, vco_max = '0;
  logic [15:0] m_min = '0, m_max = '0, n_min = '0, n_max = '0;
  logic [3:0]  r_min = '0, r_max = '0;
  logic        busy, done, error;
  logic [15:0] m_out, n_out;
  logic [3:0]  r_out;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pll_param_search u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .f_want(f_want), .f_base(f_base),
    .m_min(m_min), .m_max(m_max), .n_min(n_min), .n_max(n_max),
    .r_min(r_min), .r_max(r_max), .vco_min(vco_min), .vco_max(vco_max),
    .busy(busy), .done(done), .error(error),
    .m_out(m_out), .n_out(n_out), .r_out(r_out)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ref_calc(
    input  logic [31:0] fw, fb, vmn, vmx,
    input  logic [15:0] mlo, mhi, nlo, nhi,
    input  logic [3:0]  rlo, rhi,
    output logic        e,
    output logic [15:0] bm, bn,
    output logic [3:0]  br);
    logic [31:0] v, est, d, best, prod;
    logic [16:0] am, an;
    logic [3:0]  ar;
    e = 1'b0; bm = '0; bn = '0; br = '0;
    ar = rhi;
    v  = fw << ar;
    if ((v >> ar) != fw) begin e = 1'b1; return; end
    while (ar > rlo && v > vmx) begin ar = ar - 1'b1; v = v >> 1; end
    if (v < vmn || v > vmx) begin e = 1'b1; return; end
    br = ar;
    best = '1;
    am = {1'b0, mlo};
    an = {1'b0, nlo};
    while (am <= {1'b0, mhi} && an <= {1'b0, nhi}) begin
      prod = fb * {15'b0, am};
      est  = (an == 0) ? 32'hFFFF_FFFF : prod / {15'b0, an};
      d    = (est > v) ? est - v : v - est;
      if (d < best) begin best = d; bm = am[15:0]; bn = an[15:0]; end
      if (est <= v) am = am + 1'b1;
      else          an = an + 1'b1;
    end
  endtask

  task automatic setup(input logic [31:0] fw, fb, vmn, vmx,
                       input logic [15:0] mlo, mhi, nlo, nhi,
                       input logic [3:0] rlo, rhi);
    f_want = fw; f_base = fb; vco_min = vmn; vco_max = vmx;
    m_min = mlo; m_max = mhi; n_min = nlo; n_max = nhi;
    r_min = rlo; r_max = rhi;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 40000) begin
      @(negedge clk);
      n++;
    end
    if (!done) chk(1'b0, {req, " watchdog"}, 0, 1);
  endtask

  // run the request currently on the inputs and compare with the model
  task automatic run_and_check(input string req, input bit busy_restart);
    logic e; logic [15:0] bm, bn; logic [3:0] br;
    ref_calc(f_want, f_base, vco_min, vco_max, m_min, m_max, n_min, n_max,
             r_min, r_max, e, bm, bn, br);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1 && done == 1'b0, "R2 busy after start", {busy, done}, 2'b10);
    if (busy_restart) begin
      // R2: a second start while busy must not change the request
      f_want = f_want + 32'd777; m_max = m_max + 16'd3; r_max = 4'd0;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_done(req);
    chk(error == e, {req, " error"}, error, e);
    chk(m_out == bm, {req, " m_out"}, m_out, bm);
    chk(n_out == bn, {req, " n_out"}, n_out, bn);
    chk(r_out == br, {req, " r_out"}, r_out, br);
    chk(busy == 1'b0, {req, " busy low at done"}, busy, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({busy, done, error} == 3'b000, "R1 flags in reset", {busy, done, error}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({busy, done, error} == 3'b000 && m_out == 0 && n_out == 0 && r_out == 0,
        "R1 state after reset", {busy, done, error, m_out, n_out, r_out}, 0);

    // R3 overflow in the left shift
    setup(32'hFFFF_0000, 32'd14318, 32'd1000, 32'hFFFF_FFFF, 16'd1, 16'd20, 16'd1, 16'd10, 4'd0, 4'd2);
    run_and_check("R3 overflow", 1'b0);
    chk(error == 1'b1, "R3 overflow flagged", error, 1);

    // R4 exponent reduction: 1000<<5 = 32000 -> 16000 -> 8000, R = 3
    setup(32'd1000, 32'd1000, 32'd4000, 32'd9000, 16'd1, 16'd20, 16'd1, 16'd10, 4'd0, 4'd5);
    run_and_check("R4 reduce", 1'b0);
    chk(r_out == 4'd3 && error == 1'b0, "R4 exponent three", r_out, 3);

    // R5 floor stops reduction at 16000, above window
    setup(32'd1000, 32'd1000, 32'd4000, 32'd9000, 16'd1, 16'd20, 16'd1, 16'd10, 4'd4, 4'd5);
    run_and_check("R5 floor", 1'b0);
    chk(error == 1'b1 && m_out == 0, "R5 window error", {error, m_out}, 17'h10000);

    // R5 target below window
    setup(32'd100, 32'd1000, 32'd4000, 32'd9000, 16'd1, 16'd20, 16'd1, 16'd10, 4'd0, 4'd1);
    run_and_check("R5 below", 1'b0);

    // R6 empty M range
    setup(32'd1000, 32'd1000, 32'd500, 32'd9000, 16'd5, 16'd4, 16'd1, 16'd10, 4'd0, 4'd2);
    run_and_check("R6 empty walk", 1'b0);
    chk(m_out == 0 && n_out == 0 && r_out == 4'd2 && error == 0, "R6 empty result",
        {m_out, n_out, r_out}, {16'd0, 16'd0, 4'd2});

    // R8 ties: estimates 1000,2000,1000,1500 vs 1250 -> keep (1,1)
    setup(32'd1250, 32'd1000, 32'd500, 32'd9000, 16'd1, 16'd3, 16'd1, 16'd2, 4'd0, 4'd0);
    run_and_check("R8 tie", 1'b0);
    chk(m_out == 1 && n_out == 1, "R8 earliest pair", {m_out, n_out}, {16'd1, 16'd1});

    // R9 exact hit reachable only through the step rule: (3,2)
    setup(32'd1500, 32'd1000, 32'd500, 32'd9000, 16'd1, 16'd4, 16'd1, 16'd4, 4'd0, 4'd0);
    run_and_check("R9 step", 1'b0);
    chk(m_out == 3 && n_out == 2, "R9 exact pair", {m_out, n_out}, {16'd3, 16'd2});

    // R7 divisor zero and truncated product
    setup(32'd5000, 32'h8000_0000, 32'd1, 32'hFFFF_FFFF, 16'd1, 16'd6, 16'd0, 16'd3, 4'd0, 4'd0);
    run_and_check("R7 zero divisor", 1'b0);

    // R10 hold after done
    begin
      logic [35:0] snap;
      snap = {m_out, n_out, r_out};
      repeat (6) @(negedge clk);
      chk(done == 1'b1 && {m_out, n_out, r_out} == snap, "R10 hold", {m_out, n_out, r_out}, snap);
    end

    // R2 start while busy is ignored
    setup(32'd25175, 32'd14318, 32'd100000, 32'd250000, 16'd2, 16'd40, 16'd1, 16'd12, 4'd0, 4'd3);
    run_and_check("R2 ignore restart", 1'b1);

    // random requests, R7 R8 R9 through the model
    for (int i = 0; i < 25; i++) begin
      logic [15:0] mlo, nlo;
      logic [3:0] rlo;
      mlo = 16'd1 + 16'($urandom % 8);
      nlo = 16'd1 + 16'($urandom % 4);
      rlo = 4'($urandom % 3);
      setup(32'd1000 + $urandom % 50000, 32'd10000 + $urandom % 20000,
            32'd20000, 32'd200000 + $urandom % 200000,
            mlo, mlo + 16'($urandom % 40), nlo, nlo + 16'($urandom % 16),
            rlo, rlo + 4'($urandom % 3));
      run_and_check("R7 R9 random", 1'b0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL global watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule